// File: doc/BRIEF.md
# Phase-Modulated Sine Oscillator

This block is a direct digital synthesis core. It advances a wide phase accumulator by a tuning word on every enabled clock, adds a selectable phase offset to the top bits of that phase, and turns the result into a sine amplitude through a quarter-wave lookup table. The output is an offset-binary sample word, ready for a digital-to-analog converter that sits outside the block.

Two tuning words and four phase offsets come in as plain inputs, driven by a separate register file. A one-bit input chooses the tuning word and a two-bit input chooses the offset. The two choices give frequency-shift and phase-shift keying with no reprogramming. The frequency selection never reloads the accumulator, so a frequency hop keeps the phase continuous. The output frequency is the selected word times the clock rate divided by 2^ACC_W.

An active-low reset empties the accumulator and the pipeline, which puts the output at midscale. The words themselves are left alone. An active-low sleep input freezes every register in the block.

Top module: `pm_nco`

## Requirements
- R1: On every enabled edge the accumulator adds the selected tuning word modulo 2^ACC_W (default 32 bits). With a word of 0xC000_0000 the phase steps 0, 3072, 2048, 1024 and then wraps.
- R2: `freqSel` = 0 selects `freqWordA` and `freqSel` = 1 selects `freqWordB`, sampled on the rising clock edge.
- R3: `phaseSel` picks one of four 12-bit offset slots packed in `phaseOfs`. Value 0 selects bits [11:0], 1 selects bits [23:12], 2 selects bits [35:24] and 3 selects bits [47:36].
- R4: The table phase is the top 12 accumulator bits plus the selected offset, modulo 4096. One offset step is 2π/4096.
- R5: The sample is 512 + round(511·sin(2π·θ/4096)) within ±2 LSB, where θ is the table phase. It is exact at θ = 0, 1024, 2048 and 3072 (codes 512, 1023, 512, 1), and it never reads 0.
- R6: A change in a select input, or in the value of a selected word, is sampled at an edge. It first shows at the output after the sixth enabled edge counted from that one, and the output still shows the old value after the fifth.
- R7: While `rstN` is low at an edge, the accumulator and pipeline clear and the output reads 512. The tuning and offset words are not touched. After release the output follows an accumulator that starts from zero.
- R8: Edges with `sleepN` low change no state and the output holds its code. On wake-up the sequence resumes exactly where it stopped.
- R9: Switching `freqSel` changes only the step size. The accumulator carries on from its current value, with no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous accumulator and pipeline clear |
| sleepN | input | 1 | Active-low freeze of all registers |
| freqSel | input | 1 | Tuning-word select |
| phaseSel | input | SEL_W (2) | Phase-offset slot select |
| freqWordA | input | ACC_W (32) | Tuning word used when freqSel is 0 |
| freqWordB | input | ACC_W (32) | Tuning word used when freqSel is 1 |
| phaseOfs | input | OFS_COUNT·PHASE_W (48) | Four packed phase offsets, slot 0 in the low bits |
| sample | output | AMP_W (10) | Offset-binary sine amplitude |

## Verification
An input sampled at edge n first shows in `sample` after edge n+5. Before that it passes through the select registers, the accumulator, the phase adder, the quadrant fold, the table read and the output register. The bench drives on falling edges. It keeps an independent history of ideal phases indexed by the count of enabled edges, so each falling-edge comparison uses the entry from five enabled edges earlier, and edges skipped in sleep are left out of the count. The latency checks sample one cycle before and one cycle after that point. In the sleep and reset cases the output is held or at midscale from the very next edge.

// File: rtl/pm_nco_pkg.sv
`timescale 1ns/1ps
package pm_nco_pkg;

  // Strobes from the control block to the datapath stages.
  typedef struct packed {
    logic clear;    // synchronous clear of accumulator and pipeline
    logic advance;  // enable for every register in the chain
  } nco_strobe_t;

endpackage

// File: rtl/pm_nco_ctrl.sv
`timescale 1ns/1ps
module pm_nco_ctrl
  import pm_nco_pkg::*;
(
  input  logic        rstN,
  input  logic        sleepN,
  output nco_strobe_t strobe
);

  // Reset wins over sleep: a cleared pipeline must read midscale.
  always_comb begin
    strobe.clear   = !rstN;
    strobe.advance = rstN && sleepN;
  end

endmodule

// File: rtl/pm_nco_datapath.sv
`timescale 1ns/1ps
module pm_nco_datapath
  import pm_nco_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int PHASE_W   = 12,
  parameter int OFS_COUNT = 4,
  parameter int SEL_W     = $clog2(OFS_COUNT)
) (
  input  logic                         clk,
  input  nco_strobe_t                  strobe,
  input  logic                         freqSel,
  input  logic [SEL_W-1:0]             phaseSel,
  input  logic [ACC_W-1:0]             freqWordA,
  input  logic [ACC_W-1:0]             freqWordB,
  input  logic [OFS_COUNT*PHASE_W-1:0] phaseOfs,
  output logic [PHASE_W-1:0]           phaseOut
);

  logic [PHASE_W-1:0] ofsSlot [OFS_COUNT];

  for (genvar i = 0; i < OFS_COUNT; i++) begin : g_slot
    assign ofsSlot[i] = phaseOfs[i*PHASE_W +: PHASE_W];
  end

  logic [ACC_W-1:0]   incReg;
  logic [PHASE_W-1:0] ofsReg;
  logic [ACC_W-1:0]   accReg;
  logic [PHASE_W-1:0] ofsDly;
  logic [PHASE_W-1:0] phaseReg;

  // Stage 1 samples selections, stage 2 accumulates, stage 3 adds offset.
  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      incReg   <= '0;
      ofsReg   <= '0;
      accReg   <= '0;
      ofsDly   <= '0;
      phaseReg <= '0;
    end else if (strobe.advance) begin
      incReg   <= freqSel ? freqWordB : freqWordA;
      ofsReg   <= ofsSlot[phaseSel];
      accReg   <= accReg + incReg;
      ofsDly   <= ofsReg;
      phaseReg <= accReg[ACC_W-1 -: PHASE_W] + ofsDly;
    end
  end

  assign phaseOut = phaseReg;

endmodule

// File: rtl/pm_nco_sine.sv
`timescale 1ns/1ps
module pm_nco_sine
  import pm_nco_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int AMP_W   = 10
) (
  input  logic               clk,
  input  nco_strobe_t        strobe,
  input  logic [PHASE_W-1:0] phaseIn,
  output logic [AMP_W-1:0]   sample
);

  localparam int QW    = PHASE_W - 2;
  localparam int QN    = 1 << QW;
  localparam int MAG_W = AMP_W - 1;
  localparam int PEAK  = (1 << MAG_W) - 1;
  localparam logic [AMP_W-1:0] MID_CODE = {1'b1, {(AMP_W-1){1'b0}}};

  // Rational sine approximation over the first quadrant, rounded.
  function automatic int quarterSine(input int k);
    longint u, s, num, den;
    u   = longint'(k) * longint'(2*QN - k);
    s   = longint'(2*QN) * longint'(2*QN);
    num = longint'(PEAK) * 64'd16 * u;
    den = 64'd5 * s - 64'd4 * u;
    return int'((64'd2 * num + den) / (64'd2 * den));
  endfunction

  logic [MAG_W-1:0] quarterRom [QN+1];

  for (genvar k = 0; k <= QN; k++) begin : g_rom
    localparam int VAL = quarterSine(k);
    assign quarterRom[k] = VAL[MAG_W-1:0];
  end

  logic [QW:0]      foldIdx;
  logic             negA;
  logic [MAG_W-1:0] magB;
  logic             negB;

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      foldIdx <= '0;
      negA    <= 1'b0;
      magB    <= '0;
      negB    <= 1'b0;
      sample  <= MID_CODE;
    end else if (strobe.advance) begin
      // Quadrants 1 and 3 read the table mirrored.
      foldIdx <= phaseIn[PHASE_W-2] ? ((QW+1)'(QN) - {1'b0, phaseIn[QW-1:0]})
                                    : {1'b0, phaseIn[QW-1:0]};
      negA    <= phaseIn[PHASE_W-1];
      magB    <= quarterRom[foldIdx];
      negB    <= negA;
      sample  <= negB ? (MID_CODE - {1'b0, magB}) : (MID_CODE + {1'b0, magB});
    end
  end

endmodule

// File: rtl/pm_nco.sv
`timescale 1ns/1ps
module pm_nco
  import pm_nco_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int PHASE_W   = 12,
  parameter int AMP_W     = 10,
  parameter int OFS_COUNT = 4,
  localparam int SEL_W    = $clog2(OFS_COUNT)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sleepN,
  input  logic                         freqSel,
  input  logic [SEL_W-1:0]             phaseSel,
  input  logic [ACC_W-1:0]             freqWordA,
  input  logic [ACC_W-1:0]             freqWordB,
  input  logic [OFS_COUNT*PHASE_W-1:0] phaseOfs,
  output logic [AMP_W-1:0]             sample
);

  nco_strobe_t        strobe;
  logic [PHASE_W-1:0] phaseBus;

  pm_nco_ctrl u_ctrl (
    .rstN   (rstN),
    .sleepN (sleepN),
    .strobe (strobe)
  );

  pm_nco_datapath #(
    .ACC_W     (ACC_W),
    .PHASE_W   (PHASE_W),
    .OFS_COUNT (OFS_COUNT),
    .SEL_W     (SEL_W)
  ) u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .freqSel   (freqSel),
    .phaseSel  (phaseSel),
    .freqWordA (freqWordA),
    .freqWordB (freqWordB),
    .phaseOfs  (phaseOfs),
    .phaseOut  (phaseBus)
  );

  pm_nco_sine #(
    .PHASE_W (PHASE_W),
    .AMP_W   (AMP_W)
  ) u_sine (
    .clk     (clk),
    .strobe  (strobe),
    .phaseIn (phaseBus),
    .sample  (sample)
  );

endmodule

// File: rtl/pm_nco_sva.sv
`timescale 1ns/1ps
module pm_nco_sva #(
  parameter int ACC_W     = 32,
  parameter int PHASE_W   = 12,
  parameter int AMP_W     = 10,
  parameter int OFS_COUNT = 4,
  parameter int SEL_W     = 2
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         sleepN,
  input logic                         freqSel,
  input logic [SEL_W-1:0]             phaseSel,
  input logic [ACC_W-1:0]             freqWordA,
  input logic [ACC_W-1:0]             freqWordB,
  input logic [OFS_COUNT*PHASE_W-1:0] phaseOfs,
  input logic [AMP_W-1:0]             sample
);

  localparam logic [AMP_W-1:0] MID_CODE = {1'b1, {(AMP_W-1){1'b0}}};

  logic rstLowPrev;
  always_ff @(posedge clk) rstLowPrev <= !rstN;

  always @(negedge clk) begin
    if (rstLowPrev)
      AST_RESET_MIDSCALE: assert (sample == MID_CODE) else $error("reset did not give midscale"); // R7
  end

  // Count consecutive enabled edges with zero step and an unchanged offset.
  logic [ACC_W-1:0]   selInc;
  logic [PHASE_W-1:0] selOfs;
  logic [PHASE_W-1:0] prevOfs;
  logic [3:0]         quietCnt;

  assign selInc = freqSel ? freqWordB : freqWordA;
  assign selOfs = phaseOfs[phaseSel*PHASE_W +: PHASE_W];

  always_ff @(posedge clk) begin
    prevOfs <= selOfs;
    if (rstN && sleepN && selInc == '0 && selOfs == prevOfs) begin
      if (quietCnt != 4'd15) quietCnt <= quietCnt + 4'd1;
    end else begin
      quietCnt <= '0;
    end
  end

  AST_STEADY_AFTER_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt >= 4'd8) |-> $stable(sample)); // R6

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepN) |=> $stable(sample)); // R8

  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    sample != '0); // R5

endmodule

bind pm_nco pm_nco_sva #(
  .ACC_W     (ACC_W),
  .PHASE_W   (PHASE_W),
  .AMP_W     (AMP_W),
  .OFS_COUNT (OFS_COUNT),
  .SEL_W     (SEL_W)
) u_check (
  .clk       (clk),
  .rstN      (rstN),
  .sleepN    (sleepN),
  .freqSel   (freqSel),
  .phaseSel  (phaseSel),
  .freqWordA (freqWordA),
  .freqWordB (freqWordB),
  .phaseOfs  (phaseOfs),
  .sample    (sample)
);

// File: tb/pm_nco_tb.sv
`timescale 1ns/1ps
module pm_nco_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sleepN = 1'b1;
  logic        freqSel = 1'b0;
  logic [1:0]  phaseSel = 2'd0;
  logic [31:0] fA = '0;
  logic [31:0] fB = '0;
  logic [47:0] ofs = '0;
  logic [9:0]  sample;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pm_nco u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .sleepN    (sleepN),
    .freqSel   (freqSel),
    .phaseSel  (phaseSel),
    .freqWordA (fA),
    .freqWordB (fB),
    .phaseOfs  (ofs),
    .sample    (sample)
  );

  // Independent model: ideal phase per enabled edge, output due five enabled edges later.
  int          mCount = 0;
  logic [31:0] mAcc = '0;
  logic [11:0] mHist [8];

  always @(posedge clk) begin
    if (!rstN) begin
      mCount <= 0;
      mAcc   <= '0;
    end else if (sleepN) begin
      logic [31:0] nAcc;
      nAcc = mAcc + (freqSel ? fB : fA);
      mAcc <= nAcc;
      mHist[(mCount + 1) % 8] <= nAcc[31:20] + ofs[phaseSel*12 +: 12];
      mCount <= mCount + 1;
    end
  end

  function automatic int sineCode(input logic [11:0] th);
    real x;
    x = 511.0 * $sin(2.0 * 3.14159265358979 * real'(th) / 4096.0);
    return 512 + $rtoi(x >= 0.0 ? x + 0.5 : x - 0.5);
  endfunction

  function automatic int expNow();
    return (mCount >= 6) ? sineCode(mHist[(mCount - 5) % 8]) : 512;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkVal(input string req, input int expv);
    nChk++;
    if (int'(sample) != expv) begin
      nFail++;
      $display("FAIL %s: sample=%0d expected=%0d", req, sample, expv);
    end
  endtask

  task automatic chkModel(input string req);
    int e, d;
    e = expNow();
    d = int'(sample) - e;
    nChk++;
    if (d > 2 || d < -2) begin
      nFail++;
      $display("FAIL %s: sample=%0d expected=%0d (+/-2)", req, sample, e);
    end
  endtask

  // R7: reset holds midscale even with a live tuning word
  task automatic tReset();
    rstN = 1'b0;
    fA = 32'h0100_0000;
    step(4);
    chkVal("R7", 512);
  endtask

  // R3, R5: each offset slot on a stopped accumulator
  task automatic tOffsets();
    fA = '0;
    ofs = {12'd512, 12'd0, 12'd3072, 12'd1024};
    rstN = 1'b1;
    phaseSel = 2'd0; step(6); chkVal("R3", 1023);
    phaseSel = 2'd1; step(6); chkVal("R3", 1);
    phaseSel = 2'd2; step(6); chkVal("R5", 512);
    phaseSel = 2'd3; step(6); chkModel("R3");
  endtask

  // R6: select change and word change both show on the sixth edge
  task automatic tLatency();
    phaseSel = 2'd2; step(8);
    phaseSel = 2'd0;
    step(5); chkVal("R6", 512);
    step(1); chkVal("R6", 1023);
    ofs[11:0] = 12'd3072;
    step(5); chkVal("R6", 1023);
    step(1); chkVal("R6", 1);
  endtask

  // R1: wrap of the accumulator with a quarter-turn step
  task automatic tWrap();
    ofs[11:0] = 12'd0;
    phaseSel = 2'd0;
    fA = 32'hC000_0000;
    step(6);
    for (int i = 0; i < 8; i++) begin
      step(1);
      chkModel("R1");
    end
  endtask

  // R4, R5: slow sweep with a nonzero offset added
  task automatic tSweep();
    fA = 32'h0123_4567;
    phaseSel = 2'd3;
    for (int i = 0; i < 60; i++) begin
      step(1);
      chkModel("R4");
    end
  endtask

  // R2, R9: hopping between two words keeps phase continuous
  task automatic tSwitch();
    fB = 32'h0A00_0000;
    for (int i = 0; i < 42; i++) begin
      if (i % 7 == 0) freqSel = ~freqSel;
      step(1);
      chkModel("R9");
    end
    freqSel = 1'b1;
    step(6);
    chkModel("R2");
  endtask

  // R8: sleep freezes output and state
  task automatic tSleep();
    int hold;
    hold = int'(sample);
    sleepN = 1'b0;
    for (int i = 0; i < 10; i++) begin
      step(1);
      chkVal("R8", hold);
    end
    sleepN = 1'b1;
    for (int i = 0; i < 12; i++) begin
      step(1);
      chkModel("R8");
    end
  endtask

  // R7: reset mid-run, words kept, restart from zero phase
  task automatic tMidReset();
    rstN = 1'b0;
    step(2);
    chkVal("R7", 512);
    rstN = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step(1);
      chkModel("R7");
    end
  endtask

  initial begin
    step(1);
    tReset();
    tOffsets();
    tLatency();
    tWrap();
    tSweep();
    tSwitch();
    tSleep();
    tMidReset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule